// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of a 1024-row dynamic memory refreshed on time. A free-running interval counter turns the retention window into one refresh obligation per row interval, measured in clock cycles. Each obligation goes into a small backlog. The block asks the access sequencer for the memory through a request/grant handshake. It raises the request only while that sequencer reports its row strobe idle and precharged. When granted, the block drives one complete refresh cycle on the strobe and address pins.

Two refresh flavours are supported, chosen per cycle by a mode input. In the column-first flavour the column strobe falls one cycle ahead of the row strobe, and the memory's own row counter picks the row. In the row-address flavour the block drives a 10-bit row from its own counter while only the row strobe pulses. A second input stretches the interval to suit parts with an extended retention window. Obligations that cannot be served while the sequencer is busy build up in the backlog, which saturates. Above a threshold the block raises an urgency flag so that the arbiter ranks refresh above host traffic.

Top module: `refresh_sched`

## Requirements
- R1: With `ext_period_i` low, one refresh obligation arises every NORM_CYC clocks, where NORM_CYC = CLK_MHZ*16400/1024. With grants given at once, successive row-strobe falls are exactly NORM_CYC clocks apart.
- R2: With `ext_period_i` high, the interval is EXT_CYC = CLK_MHZ*128000/1024 clocks, and successive falls are that far apart.
- R3: `ref_req_o` is high only while the backlog is non-empty, `seq_idle_i` is high and no refresh cycle is running. A cycle starts only after a clock edge at which both `ref_req_o` and `ref_gnt_i` are high.
- R4: The row strobe `dram_ras_n_o` (active low) stays low for exactly RAS_LOW_CYC clocks. It then stays high for PRECH_CYC clocks with `ref_busy_o` high before the block is free again.
- R5: A column-first refresh (`row_mode_i`=0 at grant) drives `dram_cas_n_o` low in the clock before the row strobe falls. It holds it low while the row strobe is low and drives the address to 0.
- R6: A row-address refresh (`row_mode_i`=1 at grant) keeps `dram_cas_n_o` high and drives the row counter on `dram_addr_o` while the row strobe is low.
- R7: The row counter starts at 0 after reset. It advances by one after each row-address refresh and wraps from 1023 to 0. Column-first refreshes leave it unchanged.
- R8: The backlog saturates at 8. After a long stall it releases exactly 8 back-to-back refresh cycles.
- R9: `ref_urgent_o` is high exactly while the backlog holds more than 4 obligations.
- R10: During and right after reset, both strobes are high, the address is 0, and `ref_req_o`, `ref_busy_o` and `ref_urgent_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_period_i | input | 1 | 1 selects the extended refresh interval |
| row_mode_i | input | 1 | 1 selects row-address refresh, 0 column-first refresh; sampled at grant |
| seq_idle_i | input | 1 | Access sequencer reports row strobe idle and precharged |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_gnt_i | input | 1 | Grant from the arbiter |
| ref_urgent_o | output | 1 | Backlog above threshold; refresh outranks host accesses |
| ref_busy_o | output | 1 | A refresh cycle is in progress |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_addr_o | output | 10 | Row address during row-address refresh, else 0 |

## Verification
The bench targets the row counter wrap after 1024 row-address refreshes: a counter that saturated or skipped would repeat 1023 or jump past 0. It holds the sequencer busy for twelve intervals and then counts the burst that follows. A backlog that failed to saturate, or saturated at the wrong depth, would release too many or too few cycles. It brackets the urgency threshold one obligation either side, and it checks that the column strobe leads the row strobe in column-first mode. It also interleaves the two refresh flavours, so that a column-first cycle that wrongly advanced the row counter would show up as a skipped row.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        RC_IDLE  = 2'd0,
        RC_LEAD  = 2'd1,
        RC_STROBE = 2'd2,
        RC_PRECH = 2'd3
    } rc_state_e;

    typedef enum logic {
        RK_CBR  = 1'b0,
        RK_ROWA = 1'b1
    } rc_kind_e;

endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
    parameter int unsigned NORM_CYC = 1601,
    parameter int unsigned EXT_CYC  = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    output logic tick_o
);
    localparam int unsigned LIM_MAX = (NORM_CYC > EXT_CYC) ? NORM_CYC : EXT_CYC;
    localparam int unsigned CNT_W   = (LIM_MAX > 1) ? $clog2(LIM_MAX) : 1;
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_CYC - 1);
    localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } iv_state_t;

    iv_state_t s_d, s_q;
    logic [CNT_W-1:0] last;
    logic             wrap;

    always_comb begin
        s_d  = s_q;
        last = ext_i ? EXT_LAST : NORM_LAST;
        wrap = (s_q.cnt >= last);
        if (wrap) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o = wrap;

endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int unsigned PEND_MAX = 8,
    parameter int unsigned URG_TH   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic take_i,
    output logic any_o,
    output logic urgent_o
);
    localparam int unsigned PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] P_FULL = PW'(PEND_MAX);
    localparam logic [PW-1:0] P_TH   = PW'(URG_TH);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } bl_state_t;

    bl_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case ({add_i, take_i})
            2'b10: begin
                if (s_q.cnt != P_FULL) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            2'b01: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign any_o    = (s_q.cnt != '0);
    assign urgent_o = (s_q.cnt > P_TH);

endmodule

// File: rtl/refresh_cycle.sv
module refresh_cycle
    import refresh_pkg::*;
#(
    parameter int unsigned RAS_LOW_CYC = 6,
    parameter int unsigned PRECH_CYC   = 5,
    parameter int unsigned ROW_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rowmode_i,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             busy_o
);
    localparam int unsigned TMAX = (RAS_LOW_CYC > PRECH_CYC) ? RAS_LOW_CYC : PRECH_CYC;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] RAS_LAST = TW'(RAS_LOW_CYC - 1);
    localparam logic [TW-1:0] RP_LAST  = TW'(PRECH_CYC - 1);
    localparam int unsigned ROWS = 1 << ROW_W;
    localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(ROWS - 1);

    typedef struct packed {
        rc_state_e        st;
        logic [TW-1:0]    tmr;
        rc_kind_e         kind;
        logic [ROW_W-1:0] row;
    } cy_state_t;

    cy_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            RC_IDLE: begin
                if (start_i) begin
                    s_d.st   = RC_LEAD;
                    s_d.tmr  = '0;
                    s_d.kind = rowmode_i ? RK_ROWA : RK_CBR;
                end
            end
            RC_LEAD: begin
                s_d.st  = RC_STROBE;
                s_d.tmr = '0;
            end
            RC_STROBE: begin
                if (s_q.tmr == RAS_LAST) begin
                    s_d.st  = RC_PRECH;
                    s_d.tmr = '0;
                    if (s_q.kind == RK_ROWA) begin
                        s_d.row = (s_q.row == ROW_TOP) ? '0 : s_q.row + 1'b1;
                    end
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            RC_PRECH: begin
                if (s_q.tmr == RP_LAST) begin
                    s_d.st  = RC_IDLE;
                    s_d.tmr = '0;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            default: s_d.st = RC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= RC_IDLE;
            s_q.tmr  <= '0;
            s_q.kind <= RK_CBR;
            s_q.row  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ras_n_o = (s_q.st != RC_STROBE);
        cas_n_o = !((s_q.kind == RK_CBR) &&
                    ((s_q.st == RC_LEAD) || (s_q.st == RC_STROBE)));
        addr_o  = ((s_q.kind == RK_ROWA) && (s_q.st != RC_IDLE)) ? s_q.row : '0;
        busy_o  = (s_q.st != RC_IDLE);
    end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned CLK_MHZ       = 100,
    parameter int unsigned NORM_WIN_US   = 16400,
    parameter int unsigned EXT_WIN_US    = 128000,
    parameter int unsigned ROW_W         = 10,
    parameter int unsigned RAS_LOW_CYC   = 6,
    parameter int unsigned PRECH_CYC     = 5,
    parameter int unsigned PEND_MAX      = 8,
    parameter int unsigned URG_TH        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_period_i,
    input  logic             row_mode_i,
    input  logic             seq_idle_i,
    output logic             ref_req_o,
    input  logic             ref_gnt_i,
    output logic             ref_urgent_o,
    output logic             ref_busy_o,
    output logic             dram_ras_n_o,
    output logic             dram_cas_n_o,
    output logic [ROW_W-1:0] dram_addr_o
);
    localparam int unsigned ROWS     = 1 << ROW_W;
    localparam int unsigned NORM_CYC = (CLK_MHZ * NORM_WIN_US) / ROWS;
    localparam int unsigned EXT_CYC  = (CLK_MHZ * EXT_WIN_US) / ROWS;

    logic tick;
    logic pend_any;
    logic start;
    logic busy;

    refresh_interval #(
        .NORM_CYC (NORM_CYC),
        .EXT_CYC  (EXT_CYC)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_i  (ext_period_i),
        .tick_o (tick)
    );

    refresh_backlog #(
        .PEND_MAX (PEND_MAX),
        .URG_TH   (URG_TH)
    ) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_i    (tick),
        .take_i   (start),
        .any_o    (pend_any),
        .urgent_o (ref_urgent_o)
    );

    refresh_cycle #(
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .PRECH_CYC   (PRECH_CYC),
        .ROW_W       (ROW_W)
    ) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .rowmode_i (row_mode_i),
        .ras_n_o   (dram_ras_n_o),
        .cas_n_o   (dram_cas_n_o),
        .addr_o    (dram_addr_o),
        .busy_o    (busy)
    );

    always_comb begin
        ref_req_o  = pend_any && seq_idle_i && !busy;
        start      = ref_req_o && ref_gnt_i;
        ref_busy_o = busy;
    end

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int unsigned RAS_LOW_CYC = 6,
    parameter int unsigned PRECH_CYC   = 5
) (
    input logic clk,
    input logic rst_n,
    input logic seq_idle_i,
    input logic ref_req_o,
    input logic ref_gnt_i,
    input logic ref_urgent_o,
    input logic ref_busy_o,
    input logic dram_ras_n_o,
    input logic dram_cas_n_o
);
    int unsigned lo_q;
    int unsigned hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= 0;
            hi_q <= PRECH_CYC;
        end else begin
            lo_q <= dram_ras_n_o ? 0 : lo_q + 1;
            if (!dram_ras_n_o) begin
                hi_q <= 0;
            end else if (hi_q < PRECH_CYC) begin
                hi_q <= hi_q + 1;
            end
        end
    end

    p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n_o) |-> (lo_q == RAS_LOW_CYC));

    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n_o) |-> (hi_q >= PRECH_CYC));

    p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n_o) && !dram_cas_n_o) |-> $past(!dram_cas_n_o));

    p_cas_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n_o) |-> dram_cas_n_o);

    p_req_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> (seq_idle_i && !ref_busy_o));

    p_start_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_busy_o) |-> $past(ref_req_o && ref_gnt_i));

    p_urgent_asks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent_o && seq_idle_i && !ref_busy_o) |-> ref_req_o);

endmodule

bind refresh_sched refresh_sched_chk #(
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRECH_CYC   (PRECH_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seq_idle_i   (seq_idle_i),
    .ref_req_o    (ref_req_o),
    .ref_gnt_i    (ref_gnt_i),
    .ref_urgent_o (ref_urgent_o),
    .ref_busy_o   (ref_busy_o),
    .dram_ras_n_o (dram_ras_n_o),
    .dram_cas_n_o (dram_cas_n_o)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ   = 4;
    localparam int T_RAS = 3;
    localparam int T_RP  = 2;
    localparam int NORM  = (MHZ * 16400) / 1024;
    localparam int EXTC  = (MHZ * 128000) / 1024;
    localparam int WD_CYCLES = 150000;

    typedef struct packed {
        logic        ext;
        logic        rowm;
        logic [7:0]  n;
        logic [15:0] row0;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 1'b1, 8'd3, 16'd0},
        '{1'b0, 1'b0, 8'd2, 16'd0},
        '{1'b0, 1'b1, 8'd2, 16'd3},
        '{1'b1, 1'b0, 8'd2, 16'd0},
        '{1'b1, 1'b1, 8'd2, 16'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_period_i = 1'b0;
    logic       row_mode_i = 1'b0;
    logic       seq_idle_i = 1'b0;
    logic       ref_gnt_i = 1'b0;
    logic       ref_req_o, ref_urgent_o, ref_busy_o;
    logic       dram_ras_n_o, dram_cas_n_o;
    logic [9:0] dram_addr_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic cas_hist = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cas_hist <= dram_cas_n_o;
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    refresh_sched #(
        .CLK_MHZ     (MHZ),
        .RAS_LOW_CYC (T_RAS),
        .PRECH_CYC   (T_RP)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_period_i (ext_period_i),
        .row_mode_i   (row_mode_i),
        .seq_idle_i   (seq_idle_i),
        .ref_req_o    (ref_req_o),
        .ref_gnt_i    (ref_gnt_i),
        .ref_urgent_o (ref_urgent_o),
        .ref_busy_o   (ref_busy_o),
        .dram_ras_n_o (dram_ras_n_o),
        .dram_cas_n_o (dram_cas_n_o),
        .dram_addr_o  (dram_addr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // Waits for one full refresh cycle; called while the row strobe is high.
    task automatic one_refresh(output int t_fall, output int addr, output bit cas_at,
                               output bit cas_pre, output int lo_w, output int prech);
        do @(negedge clk); while (dram_ras_n_o != 1'b0);
        t_fall  = cyc;
        addr    = dram_addr_o;
        cas_at  = dram_cas_n_o;
        cas_pre = cas_hist;
        lo_w = 0;
        while (!dram_ras_n_o) begin
            lo_w++;
            @(negedge clk);
        end
        prech = 0;
        while (ref_busy_o) begin
            prech++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t_fall, t_prev, addr, lo_w, prech, burst, bad_rows;
        bit cas_at, cas_pre;

        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(dram_ras_n_o && dram_cas_n_o, "R10 strobes high in reset", {dram_ras_n_o, dram_cas_n_o}, 3);
        chk(!ref_req_o && !ref_busy_o && !ref_urgent_o, "R10 flags low in reset",
            {ref_req_o, ref_busy_o, ref_urgent_o}, 0);
        chk(dram_addr_o == 0, "R10 address zero in reset", dram_addr_o, 0);
        seq_idle_i = 1'b1;
        ref_gnt_i  = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ref_req_o && dram_ras_n_o, "R10 idle after reset", ref_req_o, 0);

        // Table of mode vectors, run back to back without reset
        for (int v = 0; v < NV; v++) begin
            ext_period_i = VEC[v].ext;
            row_mode_i   = VEC[v].rowm;
            t_prev = 0;
            for (int k = 0; k < int'(VEC[v].n); k++) begin
                one_refresh(t_fall, addr, cas_at, cas_pre, lo_w, prech);
                chk(lo_w == T_RAS, "R4 row strobe low width", lo_w, T_RAS);
                chk(prech == T_RP, "R4 precharge width", prech, T_RP);
                if (VEC[v].rowm) begin
                    chk(cas_at == 1'b1, "R6 column strobe high", cas_at, 1);
                    chk(addr == int'(VEC[v].row0) + k, "R7 row address sequence", addr,
                        int'(VEC[v].row0) + k);
                end else begin
                    chk(cas_at == 1'b0 && cas_pre == 1'b0, "R5 column strobe leads",
                        {cas_pre, cas_at}, 0);
                    chk(addr == 0, "R5 address zero", addr, 0);
                end
                if (k > 0) begin
                    if (VEC[v].ext) chk(t_fall - t_prev == EXTC, "R2 extended interval",
                                        t_fall - t_prev, EXTC);
                    else            chk(t_fall - t_prev == NORM, "R1 normal interval",
                                        t_fall - t_prev, NORM);
                end
                t_prev = t_fall;
            end
        end

        // Backlog saturation and urgency, extended interval
        seq_idle_i   = 1'b0;
        ext_period_i = 1'b1;
        row_mode_i   = 1'b0;
        do_reset();
        wait_cyc(4 * EXTC + EXTC / 2);
        chk(!ref_urgent_o, "R9 urgent low at 4 pending", ref_urgent_o, 0);
        chk(!ref_req_o, "R3 no request while sequencer busy", ref_req_o, 0);
        wait_cyc(5 * EXTC + EXTC / 2);
        chk(ref_urgent_o, "R9 urgent high at 5 pending", ref_urgent_o, 1);
        wait_cyc(12 * EXTC + 10);
        chk(!ref_req_o && dram_ras_n_o, "R3 stall holds off refresh", ref_req_o, 0);
        ref_gnt_i  = 1'b0;
        seq_idle_i = 1'b1;
        repeat (5) @(negedge clk);
        chk(ref_req_o, "R3 request when idle", ref_req_o, 1);
        chk(dram_ras_n_o && !ref_busy_o, "R3 no cycle without grant", ref_busy_o, 0);
        ref_gnt_i = 1'b1;
        burst = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!dram_ras_n_o && cas_hist == 1'b0 && !ref_busy_o) burst = burst;
            if (!dram_ras_n_o && lo_w == -1) burst = burst;
            if (!dram_ras_n_o) lo_w = -2;
            else if (lo_w == -2) begin
                burst++;
                lo_w = 0;
            end
        end
        chk(burst == 8, "R8 saturated backlog drains 8", burst, 8);
        chk(!ref_urgent_o, "R9 urgent clears after drain", ref_urgent_o, 0);

        // Row counter wrap in row-address mode, normal interval
        ext_period_i = 1'b0;
        row_mode_i   = 1'b1;
        do_reset();
        bad_rows = 0;
        for (int k = 0; k < 1025; k++) begin
            one_refresh(t_fall, addr, cas_at, cas_pre, lo_w, prech);
            if (addr != (k % 1024)) bad_rows++;
            if (k == 1023) chk(addr == 1023, "R7 last row", addr, 1023);
            if (k == 1024) chk(addr == 0, "R7 wrap to row 0", addr, 0);
        end
        chk(bad_rows == 0, "R7 full row sweep", bad_rows, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule